// File: doc/BRIEF.md
# Dual-Rail Fault-Signalling Logic Stage

This block is a clocked model of one datapath stage built in dual-rail return-to-zero form. Each logical bit travels on a pair of wires. A pair is either empty (the spacer) or carries exactly one valid value. The stage takes two dual-rail operand words and a two-bit operation select, and returns a dual-rail result word. It also drives a completion flag, a stall flag and a sticky alarm flag. The completion flag also serves as the acknowledge of a req/ack pair that is modelled synchronously to the clock.

The fourth pair code, with both wires high, is treated as an alarm and never as a don't-care. Faults that an attacker injects resolve in one of two ways. Either they raise the alarm, which floods every result pair with the alarm code, or they leave a token that can never complete, which a watchdog reports as a stall. A partial or corrupted token never produces a completion with data.

The controller is a six-state machine. The states and their transitions are:
- `ST_IDLE`: both operands are empty. It moves to `ST_FILL` when any pair becomes valid, and straight to `ST_DONE` when both words become valid together.
- `ST_FILL`: a token has started but is incomplete. It moves to `ST_DONE` once the token is complete, back to `ST_IDLE` if every pair empties, and to `ST_STALL` when the watchdog expires.
- `ST_DONE`: the result is held and completion is high. It moves to `ST_IDLE` when both words are empty and to `ST_DRAIN` when the words are only partly empty.
- `ST_DRAIN`: the token is returning to the spacer. It moves to `ST_IDLE` when both words are empty and to `ST_STALL` when the watchdog expires.
- `ST_STALL`: it moves to `ST_IDLE` once both words are empty.
- `ST_ALARM`: it is entered from any state and is left only through reset.

Top module: `dr_alarm_stage`

## Requirements
- R1: Pair i of each word sits on wires 2i+1 (the one-rail) and 2i (the zero-rail). Code 01 means 0, code 10 means 1, code 00 is the spacer and code 11 is the alarm. The result is valid one clock edge after both operands become fully valid. The operation select is 00 for XOR, 01 for AND and 10 for OR.
- R2: Completion never rises while any operand pair is still empty. An incomplete token gives no completion.
- R3: Once both operands are all-spacer, the result returns to all-spacer and completion drops, one clock edge later.
- R4: Any operand pair at 11, in any state, drives every result pair to 11, sets the alarm flag and clears completion, one clock edge later.
- R5: The alarm is sticky. While it is set, valid tokens on the inputs give neither completion nor data. Only the synchronous active-low reset clears it.
- R6: If the operation select is 11 when a token completes, the alarm is raised instead of a result.
- R7: A token that stays partly valid for STALL_LIMIT clock cycles, whether filling or draining, raises the stall flag and gives no completion. The stall flag clears once both operands are all-spacer.
- R8: Changes to the operation select while completion is high have no effect on the result being held.
- R9: Every result emitted with completion has constant weight: exactly WIDTH of its 2*WIDTH wires are high.
- R10: After reset, the result is all-spacer and completion, stall and alarm are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opa_i | input | 2*WIDTH | Dual-rail operand A |
| opb_i | input | 2*WIDTH | Dual-rail operand B |
| op_i | input | 2 | Operation select: 00 XOR, 01 AND, 10 OR, 11 illegal |
| res_o | output | 2*WIDTH | Dual-rail result |
| done_o | output | 1 | Completion (acknowledge) |
| stall_o | output | 1 | Watchdog stall indication |
| alarm_o | output | 1 | Sticky alarm flag |

## Verification
The hardest case to reach is the stall that follows a fault which strips a logic code back to the spacer in the middle of a token. Ordinary traffic never leaves a word partly valid for long. The stimulus therefore completes a token first, then clears only part of one operand and holds the inputs there past the watchdog limit, which exercises `ST_DRAIN` and its expiry. The same holding method is used in `ST_IDLE` with one spurious valid pair, to model a spacer that turns into a logic code outside any token window. Alarm injection is applied both to a held result (logic to 11) and to an idle word (spacer to 11, several bits at once).

// File: rtl/dr_pkg.sv
package dr_pkg;

    typedef enum logic [1:0] {
        OP_XOR = 2'b00,
        OP_AND = 2'b01,
        OP_OR  = 2'b10,
        OP_BAD = 2'b11
    } dr_op_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FILL  = 3'd1,
        ST_DONE  = 3'd2,
        ST_DRAIN = 3'd3,
        ST_STALL = 3'd4,
        ST_ALARM = 3'd5
    } dr_state_e;

    localparam logic [1:0] PAIR_CLEAR = 2'b00;
    localparam logic [1:0] PAIR_ZERO  = 2'b01;
    localparam logic [1:0] PAIR_ONE   = 2'b10;
    localparam logic [1:0] PAIR_ALARM = 2'b11;

endpackage

// File: rtl/dr_classify.sv
module dr_classify #(
    parameter int WIDTH = 8
) (
    input  logic [2*WIDTH-1:0] word_i,
    output logic               all_clear_o,
    output logic               all_valid_o,
    output logic               any_alarm_o,
    output logic [WIDTH-1:0]   value_o
);
    import dr_pkg::*;

    logic [WIDTH-1:0] is_clear;
    logic [WIDTH-1:0] is_valid;
    logic [WIDTH-1:0] is_alarm;

    for (genvar i = 0; i < WIDTH; i++) begin : g_pair
        logic [1:0] pair;
        assign pair        = word_i[2*i+1 -: 2];
        assign is_clear[i] = (pair == PAIR_CLEAR);
        assign is_valid[i] = (pair == PAIR_ZERO) || (pair == PAIR_ONE);
        assign is_alarm[i] = (pair == PAIR_ALARM);
        assign value_o[i]  = pair[1];
    end

    assign all_clear_o = &is_clear;
    assign all_valid_o = &is_valid;
    assign any_alarm_o = |is_alarm;

endmodule

// File: rtl/dr_logic.sv
module dr_logic #(
    parameter int WIDTH = 8
) (
    input  dr_pkg::dr_op_e   op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [2*WIDTH-1:0] rail_o
);
    import dr_pkg::*;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic r;
        always_comb begin
            unique case (op_i)
                OP_XOR:  r = a_i[i] ^ b_i[i];
                OP_AND:  r = a_i[i] & b_i[i];
                OP_OR:   r = a_i[i] | b_i[i];
                default: r = 1'b0;
            endcase
        end
        assign rail_o[2*i+1 -: 2] = r ? PAIR_ONE : PAIR_ZERO;
    end

endmodule

// File: rtl/dr_watchdog.sv
module dr_watchdog #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic en_i,
    output logic expired_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt <= '0;
        end else if (en_i && (cnt != CW'(LIMIT - 1))) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired_o = en_i && (cnt == CW'(LIMIT - 1));

    // R7
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(LIMIT));

endmodule

// File: rtl/dr_alarm_stage.sv
module dr_alarm_stage #(
    parameter int WIDTH       = 8,
    parameter int STALL_LIMIT = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2*WIDTH-1:0] opa_i,
    input  logic [2*WIDTH-1:0] opb_i,
    input  logic [1:0]         op_i,
    output logic [2*WIDTH-1:0] res_o,
    output logic               done_o,
    output logic               stall_o,
    output logic               alarm_o
);
    import dr_pkg::*;

    localparam int RW = 2 * WIDTH;

    logic             a_clear, a_valid, a_alarm;
    logic             b_clear, b_valid, b_alarm;
    logic [WIDTH-1:0] a_val, b_val;
    logic [RW-1:0]    rail_calc;
    logic [RW-1:0]    res_q;
    logic             wd_expired;
    dr_state_e        state, state_n;
    dr_op_e           op_e;

    assign op_e = dr_op_e'(op_i);

    dr_classify #(.WIDTH(WIDTH)) u_cls_a (
        .word_i(opa_i), .all_clear_o(a_clear), .all_valid_o(a_valid),
        .any_alarm_o(a_alarm), .value_o(a_val)
    );

    dr_classify #(.WIDTH(WIDTH)) u_cls_b (
        .word_i(opb_i), .all_clear_o(b_clear), .all_valid_o(b_valid),
        .any_alarm_o(b_alarm), .value_o(b_val)
    );

    dr_logic #(.WIDTH(WIDTH)) u_logic (
        .op_i(op_e), .a_i(a_val), .b_i(b_val), .rail_o(rail_calc)
    );

    dr_watchdog #(.LIMIT(STALL_LIMIT)) u_wd (
        .clk(clk), .rst_n(rst_n),
        .clr_i(state_n != state),
        .en_i((state == ST_FILL) || (state == ST_DRAIN)),
        .expired_o(wd_expired)
    );

    logic both_clear, both_valid, in_alarm;
    assign both_clear = a_clear && b_clear;
    assign both_valid = a_valid && b_valid;
    assign in_alarm   = a_alarm || b_alarm;

    // next-state logic
    always_comb begin
        state_n = state;
        if (in_alarm) begin
            state_n = ST_ALARM;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (both_valid)
                        state_n = (op_e == OP_BAD) ? ST_ALARM : ST_DONE;
                    else if (!both_clear)
                        state_n = ST_FILL;
                end
                ST_FILL: begin
                    if (both_valid)
                        state_n = (op_e == OP_BAD) ? ST_ALARM : ST_DONE;
                    else if (both_clear)
                        state_n = ST_IDLE;
                    else if (wd_expired)
                        state_n = ST_STALL;
                end
                ST_DONE: begin
                    if (both_clear)
                        state_n = ST_IDLE;
                    else if (!both_valid)
                        state_n = ST_DRAIN;
                end
                ST_DRAIN: begin
                    if (both_clear)
                        state_n = ST_IDLE;
                    else if (wd_expired)
                        state_n = ST_STALL;
                end
                ST_STALL: begin
                    if (both_clear)
                        state_n = ST_IDLE;
                end
                ST_ALARM: state_n = ST_ALARM;
                default:  state_n = ST_ALARM;
            endcase
        end
    end

    // state register and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            res_q <= '0;
        end else begin
            state <= state_n;
            if ((state_n == ST_DONE) && (state != ST_DONE) && (state != ST_DRAIN))
                res_q <= rail_calc;
        end
    end

    // outputs
    always_comb begin
        res_o   = '0;
        done_o  = 1'b0;
        stall_o = 1'b0;
        alarm_o = 1'b0;
        unique case (state)
            ST_IDLE, ST_FILL: ;
            ST_DONE, ST_DRAIN: begin
                res_o  = res_q;
                done_o = 1'b1;
            end
            ST_STALL: stall_o = 1'b1;
            ST_ALARM: begin
                res_o   = '1;
                alarm_o = 1'b1;
            end
            default: begin
                res_o   = '1;
                alarm_o = 1'b1;
            end
        endcase
    end

    // R2
    done_needs_full_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(a_valid && b_valid));

    // R9
    done_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($countones(res_o) == WIDTH));

    // R5
    alarm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_o |=> alarm_o);

    // R4
    alarm_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_o) |-> $past(a_alarm || b_alarm || (op_i == 2'b11)));

    // R7
    stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall_o) |-> $past(!(a_clear && b_clear)));

endmodule

// File: tb/dr_alarm_stage_test.sv
module dr_alarm_stage_test;

    localparam int W   = 8;
    localparam int LIM = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [2*W-1:0] opa = '0;
    logic [2*W-1:0] opb = '0;
    logic [1:0]     op  = 2'b00;
    logic [2*W-1:0] res;
    logic           done, stall, alarm;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    dr_alarm_stage #(.WIDTH(W), .STALL_LIMIT(LIM)) uut (
        .clk(clk), .rst_n(rst_n), .opa_i(opa), .opb_i(opb), .op_i(op),
        .res_o(res), .done_o(done), .stall_o(stall), .alarm_o(alarm)
    );

    // {a, b, op}
    localparam logic [17:0] VEC [10] = '{
        {8'h00, 8'h00, 2'b00}, {8'hFF, 8'h0F, 2'b00}, {8'hA5, 8'h5A, 2'b00},
        {8'hFF, 8'h3C, 2'b01}, {8'hAA, 8'h55, 2'b01}, {8'h00, 8'hFF, 2'b01},
        {8'hF0, 8'h0F, 2'b10}, {8'h00, 8'h00, 2'b10}, {8'h81, 8'h18, 2'b10},
        {8'hFF, 8'hFF, 2'b00}
    };

    function automatic logic [2*W-1:0] enc(input logic [W-1:0] v);
        logic [2*W-1:0] r;
        for (int i = 0; i < W; i++) r[2*i+1 -: 2] = v[i] ? 2'b10 : 2'b01;
        return r;
    endfunction

    function automatic logic [W-1:0] ref_op(input logic [W-1:0] a, input logic [W-1:0] b,
                                             input logic [1:0] o);
        case (o)
            2'b00:   return a ^ b;
            2'b01:   return a & b;
            default: return a | b;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        opa = '0; opb = '0; op = 2'b00;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0;
        cycles(3);
        // R10: reset state
        chk(res == '0, "R10 res", res, 0);
        chk({done, stall, alarm} == 3'b000, "R10 flags", {done, stall, alarm}, 0);
        rst_n = 1'b1;
        cycles(1);

        // table walk: R1, R3, R9
        for (int k = 0; k < 10; k++) begin
            logic [W-1:0] a, b, e;
            logic [1:0] o;
            {a, b, o} = VEC[k];
            e = ref_op(a, b, o);
            opa = enc(a); opb = enc(b); op = o;
            cycles(1);
            chk(done == 1'b1, "R1 done", done, 1);
            chk(res == enc(e), "R1 result", res, enc(e));
            chk($countones(res) == W, "R9 weight", $countones(res), W);
            opa = '0; opb = '0;
            cycles(1);
            chk(done == 1'b0 && res == '0, "R3 return to spacer", {done, res}, 0);
        end

        // R2: partial operand B, then completion
        opa = enc(8'h3C); op = 2'b10;
        opb = enc(8'hC3) & 16'h00FF;
        cycles(2);
        chk(done == 1'b0, "R2 partial no done", done, 0);
        chk(res == '0, "R2 partial res", res, 0);
        opb = enc(8'hC3);
        cycles(1);
        chk(done == 1'b1 && res == enc(8'hFF), "R1 after partial", res, enc(8'hFF));

        // R8: op change while held
        op = 2'b01;
        cycles(2);
        chk(res == enc(8'hFF), "R8 op ignored", res, enc(8'hFF));
        // R6 must not trigger from op change while held
        op = 2'b11;
        cycles(1);
        chk(alarm == 1'b0 && done == 1'b1, "R8 bad op ignored", {alarm, done}, 2'b01);
        op = 2'b00;

        // R7: drain stall (logic -> clear fault mid return)
        opa = enc(8'h3C) & 16'hFF00;
        cycles(LIM - 4);
        chk(stall == 1'b0, "R7 not yet stalled", stall, 0);
        cycles(8);
        chk(stall == 1'b1 && done == 1'b0, "R7 drain stall", {stall, done}, 2'b10);
        opa = '0; opb = '0;
        cycles(1);
        chk(stall == 1'b0, "R7 stall clears", stall, 0);

        // R7: clear -> logic outside a token window
        opb = 16'h0002;
        cycles(LIM + 4);
        chk(stall == 1'b1 && done == 1'b0 && res == '0, "R7 spurious bit", {stall, done}, 2'b10);
        opb = '0;
        cycles(1);

        // R6: illegal op at completion
        op = 2'b11; opa = enc(8'h12); opb = enc(8'h34);
        cycles(1);
        chk(alarm == 1'b1 && done == 1'b0, "R6 bad op", {alarm, done}, 2'b10);
        do_reset();
        cycles(1);
        chk(alarm == 1'b0, "R5 reset clears", alarm, 0);

        // R4: logic -> 11 on a held result
        opa = enc(8'h77); opb = enc(8'h11); op = 2'b00;
        cycles(1);
        opa[5:4] = 2'b11;
        cycles(1);
        chk(alarm == 1'b1 && done == 1'b0, "R4 logic to alarm", {alarm, done}, 2'b10);
        chk(res == '1, "R4 flood", res, 16'hFFFF);

        // R5: sticky, valid tokens ignored
        opa = '0; opb = '0;
        cycles(1);
        opa = enc(8'h01); opb = enc(8'h02);
        cycles(2);
        chk(alarm == 1'b1 && done == 1'b0 && res == '1, "R5 sticky", {alarm, done}, 2'b10);

        // R4: clear -> 11, multi-bit, from idle
        do_reset();
        cycles(1);
        opb = 16'hC003;
        cycles(1);
        chk(alarm == 1'b1 && res == '1, "R4 clear to alarm", res, 16'hFFFF);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule